// File: doc/BRIEF.md
# Three-Operand NaN and Exception Flag Resolver

This block is the last stage behind a fused multiply-add datapath. The arithmetic core hands it the three source operands, the raw result it produced, the exception events it observed and the operating controls. The block decides the final result whenever the raw result is a NaN. For a NaN result it picks, in a fixed priority, between the canonical quiet NaN, a quieted signalling operand and a propagated quiet operand. Any raw result that is not a NaN is forwarded unchanged.

The block also keeps six cumulative exception flags: invalid, divide-by-zero, overflow, underflow, inexact and input-denormal. Each of the five arithmetic events is recorded only when its enable bit is set. Flush-to-zero mode changes the flags in three ways. It turns a denormal result into an underflow event. It suppresses inexact when underflow occurs. It makes denormal operands raise the input-denormal flag. Once set, a flag stays set until a clear request or reset. Every input is sampled on a clock edge where `valid_i` is high, and the result, the valid strobe and the flags appear registered one cycle later.

Top module: `fma_nan_resolver`

## Requirements
- R1: After reset, `res_o` is 0, `res_vld_o` is 0 and `flags_o` is 0.
- R2: When the raw result is not a NaN, `res_o` equals `raw_i` bit for bit, one cycle after the valid cycle, and `res_vld_o` is 1 in that cycle.
- R3: When the raw result is a NaN and no operand is a NaN, `res_o` is the canonical quiet NaN. In single precision (`dbl_i`=0) this is 0x00000000_7FC00000. In double precision (`dbl_i`=1) it is 0x7FF80000_00000000.
- R4: When the raw result is a NaN and `dnan_i` is 1, `res_o` is the canonical quiet NaN, even if operands are NaNs.
- R5: Otherwise, the first signalling NaN in the order `op_a_i`, `op_b_i`, `op_c_i` is output with its quiet bit set (bit 22 for single, bit 51 for double). A NaN is signalling when its quiet bit is 0.
- R6: When no operand is a signalling NaN, the first quiet NaN in the order a, b, c is output unchanged.
- R7: In single precision only bits 31:0 of the operands are classified, and a result chosen on the NaN path has bits 63:32 at 0.
- R8: With `ftz_i`=1, any denormal operand sets `flags_o[5]` (input-denormal). With `ftz_i`=0, denormal operands do not set it.
- R9: Event bits `evt_i` and `mask_i` map as [0] invalid, [1] divide-by-zero, [2] overflow, [3] underflow, [4] inexact. An event sets the matching `flags_o` bit only when its mask bit is 1.
- R10: With `ftz_i`=1, a denormal raw result raises the underflow event, subject to `mask_i[3]`.
- R11: Inexact is not recorded when underflow occurred (reported or raised by R10) and `ftz_i` is 1.
- R12: Flags are sticky. Flags and `res_o` change only on edges where `valid_i` or `clr_i` is high.
- R13: `clr_i` zeroes the flags at the next edge, and events presented with `valid_i` in the same cycle are still recorded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Result-valid strobe from the arithmetic core |
| dbl_i | input | 1 | 1 = double precision, 0 = single in bits 31:0 |
| ftz_i | input | 1 | Flush-to-zero enable |
| dnan_i | input | 1 | Default-NaN enable |
| op_a_i | input | 64 | Operand 1 |
| op_b_i | input | 64 | Operand 2 |
| op_c_i | input | 64 | Operand 3 |
| raw_i | input | 64 | Raw result from the arithmetic core |
| evt_i | input | 5 | Exception events raised by the arithmetic core |
| mask_i | input | 5 | Per-event flag enable |
| clr_i | input | 1 | Clear cumulative flags |
| res_o | output | 64 | Final result |
| res_vld_o | output | 1 | Final result valid |
| flags_o | output | 6 | Sticky flags: [5] input-denormal, [4:0] as `evt_i` |

## Verification
The bench builds the block with the package defaults: a 64-bit container and five masked events plus the input-denormal flag. Both precisions are selected at run time through `dbl_i`. This lets one build reach the single-precision quiet-bit position and the double-precision one. It also reaches the zeroing of the upper word on the NaN path and the case where a double-precision NaN pattern in the upper word must be ignored in single mode. The flag tests clear between scenarios, so each mask and flush interaction is observed in isolation on `flags_o`.

// File: rtl/fmr_pkg.sv
package fmr_pkg;
    localparam int XLEN   = 64;
    localparam int SP_W   = 32;
    localparam int SP_EXP = 8;
    localparam int SP_MAN = 23;
    localparam int DP_EXP = 11;
    localparam int DP_MAN = 52;
    localparam int NOPS   = 3;
    localparam int NEVT   = 5;
    localparam int NFLG   = NEVT + 1;

    localparam int EV_INV = 0;
    localparam int EV_DZ  = 1;
    localparam int EV_OVF = 2;
    localparam int EV_UNF = 3;
    localparam int EV_INX = 4;
    localparam int FL_IDN = 5;

    typedef struct packed {
        logic nan;
        logic snan;
        logic denorm;
    } opcls_t;

    function automatic logic [XLEN-1:0] canon_qnan(input logic dbl);
        logic [XLEN-1:0] v;
        if (dbl)
            v = {1'b0, {DP_EXP{1'b1}}, 1'b1, {(DP_MAN-1){1'b0}}};
        else
            v = {{(XLEN-SP_W){1'b0}}, 1'b0, {SP_EXP{1'b1}}, 1'b1, {(SP_MAN-1){1'b0}}};
        return v;
    endfunction

    function automatic logic [XLEN-1:0] quiet_bit(input logic dbl);
        logic [XLEN-1:0] one;
        one = {{(XLEN-1){1'b0}}, 1'b1};
        return dbl ? (one << (DP_MAN-1)) : (one << (SP_MAN-1));
    endfunction

    function automatic logic [XLEN-1:0] fit_width(input logic dbl, input logic [XLEN-1:0] v);
        return dbl ? v : {{(XLEN-SP_W){1'b0}}, v[SP_W-1:0]};
    endfunction
endpackage

// File: rtl/fmr_classify.sv
module fmr_classify
    import fmr_pkg::*;
(
    input  logic            dbl_i,
    input  logic [XLEN-1:0] val_i,
    output opcls_t          cls_o
);
    logic [SP_EXP-1:0] sp_exp;
    logic [SP_MAN-1:0] sp_man;
    logic [DP_EXP-1:0] dp_exp;
    logic [DP_MAN-1:0] dp_man;
    logic              exp_ones, exp_zero, man_nz, man_top;

    always_comb begin
        sp_exp = val_i[SP_W-2 -: SP_EXP];
        sp_man = val_i[SP_MAN-1:0];
        dp_exp = val_i[XLEN-2 -: DP_EXP];
        dp_man = val_i[DP_MAN-1:0];
        if (dbl_i) begin
            exp_ones = &dp_exp;
            exp_zero = ~|dp_exp;
            man_nz   = |dp_man;
            man_top  = dp_man[DP_MAN-1];
        end else begin
            exp_ones = &sp_exp;
            exp_zero = ~|sp_exp;
            man_nz   = |sp_man;
            man_top  = sp_man[SP_MAN-1];
        end
        cls_o.nan    = exp_ones & man_nz;
        cls_o.snan   = exp_ones & man_nz & ~man_top;
        cls_o.denorm = exp_zero & man_nz;
    end
endmodule

// File: rtl/fmr_nan_select.sv
module fmr_nan_select
    import fmr_pkg::*;
(
    input  logic                       dbl_i,
    input  logic                       dnan_i,
    input  logic [NOPS-1:0][XLEN-1:0]  ops_i,
    input  opcls_t [NOPS-1:0]          cls_i,
    output logic [XLEN-1:0]            nan_o
);
    logic            any_nan, any_snan;
    logic [XLEN-1:0] q_pick, s_pick;

    always_comb begin
        any_nan  = 1'b0;
        any_snan = 1'b0;
        q_pick   = '0;
        s_pick   = '0;
        // walk from last to first so the lowest index wins
        for (int i = NOPS-1; i >= 0; i--) begin
            if (cls_i[i].nan) begin
                any_nan = 1'b1;
                q_pick  = fit_width(dbl_i, ops_i[i]);
            end
            if (cls_i[i].snan) begin
                any_snan = 1'b1;
                s_pick   = fit_width(dbl_i, ops_i[i]) | quiet_bit(dbl_i);
            end
        end
        if (dnan_i || !any_nan)
            nan_o = canon_qnan(dbl_i);
        else if (any_snan)
            nan_o = s_pick;
        else
            nan_o = q_pick;
    end
endmodule

// File: rtl/fmr_flags.sv
module fmr_flags
    import fmr_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            upd_i,
    input  logic            clr_i,
    input  logic            ftz_i,
    input  logic            raw_den_i,
    input  logic            in_den_i,
    input  logic [NEVT-1:0] evt_i,
    input  logic [NEVT-1:0] mask_i,
    output logic [NFLG-1:0] flags_o
);
    typedef struct packed {
        logic [NFLG-1:0] flags;
    } fl_state_t;

    fl_state_t       st_d, st_q;
    logic            unf_evt, inx_evt;
    logic [NFLG-1:0] raised;

    always_comb begin
        unf_evt = evt_i[EV_UNF] | (ftz_i & raw_den_i);
        inx_evt = evt_i[EV_INX] & ~(unf_evt & ftz_i);
        raised  = '0;
        raised[EV_INV] = evt_i[EV_INV] & mask_i[EV_INV];
        raised[EV_DZ]  = evt_i[EV_DZ]  & mask_i[EV_DZ];
        raised[EV_OVF] = evt_i[EV_OVF] & mask_i[EV_OVF];
        raised[EV_UNF] = unf_evt       & mask_i[EV_UNF];
        raised[EV_INX] = inx_evt       & mask_i[EV_INX];
        raised[FL_IDN] = ftz_i & in_den_i;
        st_d = st_q;
        if (clr_i)
            st_d.flags = '0;
        if (upd_i)
            st_d.flags = st_d.flags | raised;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flags_o = st_q.flags;

    // R12: no flag falls without a clear
    a_r12_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_i |=> ((st_q.flags & $past(st_q.flags)) == $past(st_q.flags)));

    // R12: idle cycles leave flags alone
    a_r12_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!upd_i && !clr_i) |=> $stable(st_q.flags));

    // R9: disabled invalid event never records
    a_r9_masked_inv: assert property (@(posedge clk) disable iff (!rst_n)
        (!mask_i[EV_INV] && !clr_i) |=> (st_q.flags[EV_INV] == $past(st_q.flags[EV_INV])));

    // R13: clear with no update empties the flags
    a_r13_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !upd_i) |=> (st_q.flags == '0));
endmodule

// File: rtl/fma_nan_resolver.sv
module fma_nan_resolver
    import fmr_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            valid_i,
    input  logic            dbl_i,
    input  logic            ftz_i,
    input  logic            dnan_i,
    input  logic [63:0]     op_a_i,
    input  logic [63:0]     op_b_i,
    input  logic [63:0]     op_c_i,
    input  logic [63:0]     raw_i,
    input  logic [4:0]      evt_i,
    input  logic [4:0]      mask_i,
    input  logic            clr_i,
    output logic [63:0]     res_o,
    output logic            res_vld_o,
    output logic [5:0]      flags_o
);
    typedef struct packed {
        logic [XLEN-1:0] res;
        logic            vld;
    } top_state_t;

    logic [NOPS-1:0][XLEN-1:0] ops;
    opcls_t [NOPS-1:0]         op_cls;
    opcls_t                    raw_cls;
    logic [XLEN-1:0]           nan_res;
    logic                      in_den;
    logic                      raw_nan;
    top_state_t                st_d, st_q;

    assign ops = {op_c_i, op_b_i, op_a_i};

    for (genvar g = 0; g < NOPS; g++) begin : g_cls
        fmr_classify u_cls (
            .dbl_i (dbl_i),
            .val_i (ops[g]),
            .cls_o (op_cls[g])
        );
    end

    fmr_classify u_raw_cls (
        .dbl_i (dbl_i),
        .val_i (raw_i),
        .cls_o (raw_cls)
    );

    fmr_nan_select u_sel (
        .dbl_i  (dbl_i),
        .dnan_i (dnan_i),
        .ops_i  (ops),
        .cls_i  (op_cls),
        .nan_o  (nan_res)
    );

    always_comb begin
        in_den = 1'b0;
        for (int i = 0; i < NOPS; i++)
            in_den = in_den | op_cls[i].denorm;
        raw_nan = raw_cls.nan | raw_cls.snan;
        st_d     = st_q;
        st_d.vld = valid_i;
        if (valid_i)
            st_d.res = raw_nan ? nan_res : raw_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    fmr_flags u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .upd_i     (valid_i),
        .clr_i     (clr_i),
        .ftz_i     (ftz_i),
        .raw_den_i (raw_cls.denorm),
        .in_den_i  (in_den),
        .evt_i     (evt_i),
        .mask_i    (mask_i),
        .flags_o   (flags_o)
    );

    assign res_o     = st_q.res;
    assign res_vld_o = st_q.vld;

    // R4: default-NaN forces the canonical pattern
    a_r4_default_nan: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && dnan_i && raw_cls.nan) |=> (res_o == $past(canon_qnan(dbl_i))));

    // R12: result holds between valid cycles
    a_r12_res_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> $stable(res_o));

    // R2: non-NaN raw result forwarded untouched
    a_r2_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && !raw_cls.nan) |=> (res_o == $past(raw_i)));
endmodule

// File: tb/test_fma_nan_resolver.sv
module test_fma_nan_resolver;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid_i = 1'b0, dbl_i = 1'b0, ftz_i = 1'b0, dnan_i = 1'b0, clr_i = 1'b0;
    logic [63:0] op_a_i = '0, op_b_i = '0, op_c_i = '0, raw_i = '0;
    logic [4:0]  evt_i = '0, mask_i = '0;
    logic [63:0] res_o;
    logic        res_vld_o;
    logic [5:0]  flags_o;
    int          n_chk = 0, n_fail = 0;
    bit          done = 1'b0;

    always #5 clk = ~clk;

    fma_nan_resolver i_fma_nan_resolver (
        .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .dbl_i(dbl_i), .ftz_i(ftz_i),
        .dnan_i(dnan_i), .op_a_i(op_a_i), .op_b_i(op_b_i), .op_c_i(op_c_i),
        .raw_i(raw_i), .evt_i(evt_i), .mask_i(mask_i), .clr_i(clr_i),
        .res_o(res_o), .res_vld_o(res_vld_o), .flags_o(flags_o)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one valid cycle; returns at the next falling edge
    task automatic issue(input logic dbl, input logic ftz, input logic dnan,
                         input logic [63:0] a, input logic [63:0] b, input logic [63:0] c,
                         input logic [63:0] raw, input logic [4:0] evt, input logic [4:0] msk);
        dbl_i = dbl; ftz_i = ftz; dnan_i = dnan;
        op_a_i = a; op_b_i = b; op_c_i = c; raw_i = raw;
        evt_i = evt; mask_i = msk; valid_i = 1'b1;
        @(negedge clk);
        valid_i = 1'b0; clr_i = 1'b0;
    endtask

    task automatic clear_flags();
        clr_i = 1'b1;
        @(negedge clk);
        clr_i = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 res", res_o, 64'h0);
        chk("R1 vld", {63'h0, res_vld_o}, 64'h0);
        chk("R1 flags", {58'h0, flags_o}, 64'h0);
    endtask

    task automatic t_pass();
        issue(0, 0, 0, 64'h0, 64'h0, 64'h0, 64'hABCD0000_3F800000, 5'h0, 5'h0);
        chk("R2 single pass", res_o, 64'hABCD0000_3F800000);
        chk("R2 vld", {63'h0, res_vld_o}, 64'h1);
        issue(1, 0, 0, 64'h0, 64'h0, 64'h0, 64'h40000000_00000000, 5'h0, 5'h0);
        chk("R2 double pass", res_o, 64'h40000000_00000000);
    endtask

    task automatic t_canon();
        issue(0, 0, 0, 64'h3F800000, 64'h0, 64'h40000000, 64'h7FC00001, 5'h0, 5'h0);
        chk("R3 single canon", res_o, 64'h00000000_7FC00000);
        issue(1, 0, 0, 64'h0, 64'h0, 64'h0, 64'h7FF00000_00000001, 5'h0, 5'h0);
        chk("R3 double canon", res_o, 64'h7FF80000_00000000);
    endtask

    task automatic t_dnan();
        issue(0, 0, 1, 64'h7FC12345, 64'h7F800001, 64'h0, 64'h7FC00000, 5'h0, 5'h0);
        chk("R4 default nan", res_o, 64'h00000000_7FC00000);
    endtask

    task automatic t_snan();
        issue(0, 0, 0, 64'h7FC00011, 64'h7F800022, 64'hFF800033, 64'h7FC00000, 5'h0, 5'h0);
        chk("R5 single snan b", res_o, 64'h00000000_7FC00022);
        issue(1, 0, 0, 64'h7FF00000_00000005, 64'h7FF80000_00000001, 64'h0, 64'h7FF80000_00000000, 5'h0, 5'h0);
        chk("R5 double snan a", res_o, 64'h7FF80000_00000005);
    endtask

    task automatic t_qnan();
        issue(0, 0, 0, 64'h3F800000, 64'hFFC00044, 64'h7FC00055, 64'h7FC00000, 5'h0, 5'h0);
        chk("R6 single qnan b", res_o, 64'h00000000_FFC00044);
        issue(1, 0, 0, 64'h0, 64'h3FF00000_00000000, 64'h7FF80000_00000077, 64'h7FF80000_00000000, 5'h0, 5'h0);
        chk("R6 double qnan c", res_o, 64'h7FF80000_00000077);
    endtask

    task automatic t_single_width();
        issue(0, 0, 0, 64'h7FF00000_3F800000, 64'h12345678_7F800009, 64'h0, 64'hFFFF0000_7FC00000, 5'h0, 5'h0);
        chk("R7 low word only", res_o, 64'h00000000_7FC00009);
    endtask

    task automatic t_in_den();
        clear_flags();
        issue(0, 1, 0, 64'h0, 64'h0, 64'h00000001, 64'h3F800000, 5'h0, 5'h1F);
        chk("R8 ftz denorm input", {58'h0, flags_o}, 64'h20);
        clear_flags();
        issue(0, 0, 0, 64'h0, 64'h0, 64'h00000001, 64'h3F800000, 5'h0, 5'h1F);
        chk("R8 no ftz", {58'h0, flags_o}, 64'h0);
    endtask

    task automatic t_mask();
        clear_flags();
        issue(0, 0, 0, 64'h0, 64'h0, 64'h0, 64'h3F800000, 5'h05, 5'h1F);
        chk("R9 all enabled", {58'h0, flags_o}, 64'h05);
        clear_flags();
        issue(0, 0, 0, 64'h0, 64'h0, 64'h0, 64'h3F800000, 5'h1F, 5'h0A);
        chk("R9 partial mask", {58'h0, flags_o}, 64'h0A);
    endtask

    task automatic t_unf();
        clear_flags();
        issue(0, 1, 0, 64'h0, 64'h0, 64'h0, 64'h00000010, 5'h0, 5'h1F);
        chk("R10 denorm result", {58'h0, flags_o}, 64'h08);
        clear_flags();
        issue(0, 1, 0, 64'h0, 64'h0, 64'h0, 64'h00000010, 5'h0, 5'h17);
        chk("R10 masked unf", {58'h0, flags_o}, 64'h0);
    endtask

    task automatic t_inx();
        clear_flags();
        issue(0, 1, 0, 64'h0, 64'h0, 64'h0, 64'h3F800000, 5'h18, 5'h1F);
        chk("R11 suppressed", {58'h0, flags_o}, 64'h08);
        clear_flags();
        issue(0, 0, 0, 64'h0, 64'h0, 64'h0, 64'h3F800000, 5'h18, 5'h1F);
        chk("R11 no ftz", {58'h0, flags_o}, 64'h18);
        clear_flags();
        issue(0, 1, 0, 64'h0, 64'h0, 64'h0, 64'h3F800000, 5'h10, 5'h1F);
        chk("R11 inexact alone", {58'h0, flags_o}, 64'h10);
    endtask

    task automatic t_sticky();
        clear_flags();
        issue(0, 0, 0, 64'h0, 64'h0, 64'h0, 64'h3F800000, 5'h01, 5'h1F);
        issue(0, 0, 0, 64'h0, 64'h0, 64'h0, 64'h40000000, 5'h02, 5'h1F);
        chk("R12 accumulate", {58'h0, flags_o}, 64'h03);
        chk("R12 res", res_o, 64'h40000000);
        evt_i = 5'h1C; raw_i = 64'h7FC00000; ftz_i = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R12 idle flags", {58'h0, flags_o}, 64'h03);
        chk("R12 idle res", res_o, 64'h40000000);
        chk("R12 idle vld", {63'h0, res_vld_o}, 64'h0);
    endtask

    task automatic t_clear();
        clr_i = 1'b1;
        issue(0, 0, 0, 64'h0, 64'h0, 64'h0, 64'h3F800000, 5'h04, 5'h1F);
        chk("R13 clear with event", {58'h0, flags_o}, 64'h04);
        clear_flags();
        chk("R13 clear", {58'h0, flags_o}, 64'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_pass();
        t_canon();
        t_dnan();
        t_snan();
        t_qnan();
        t_single_width();
        t_in_den();
        t_mask();
        t_unf();
        t_inx();
        t_sticky();
        t_clear();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule